// File: doc/BRIEF.md
# Input Change Detector with Deferred Interrupt

This block watches a small group of input levels against a stored snapshot. Any input that differs from its snapshot bit raises a sticky change flag for that input. The flags do not depend on the mask. An active-low interrupt line goes low when a flag whose mask bit is set is present. Once low, the line stays low until the next access acknowledge (`smp_clr_i`). That strobe loads the live inputs into the snapshot, clears every flag and releases the interrupt.

While the surrounding serial logic reports a read in progress (`rd_busy_i`), the block does not drive the interrupt low. It holds the qualifying change and decides at the STOP pulse. If an acknowledge inside the read has already sampled the change, the flags have been cleared and nothing remains pending, so the STOP leaves the line high. The interrupt state is an enumerated machine:

- **ST_QUIET**: line high, watching.
- **ST_HOLD**: a qualifying change seen during a read, waiting for STOP.
- **ST_FIRED**: line low, latched.

Transitions:

- **QUIET to FIRED**: a masked-in flag is present with no read in progress.
- **QUIET to HOLD**: the same condition occurs during a read.
- **HOLD to FIRED**: STOP arrives with a masked-in flag still present.
- **HOLD to QUIET**: STOP arrives with no masked-in flag present, or an acknowledge arrives.
- **FIRED to QUIET**: an acknowledge arrives.

An acknowledge takes priority over every other transition.

Top module: `input_change_irq`

## Requirements
- R1: When an input differs from its snapshot bit on a clock edge with no acknowledge, the matching bit of `flags_o` reads 1 after that edge.
- R2: A set flag stays 1 until an acknowledge, even if the input returns to its snapshot level.
- R3: Flags are set whatever the mask holds. Only a flag whose `mask` bit is 1 can drive `int_n_o` low.
- R4: An acknowledge (`smp_clr_i`=1 at an edge) loads the live inputs into `snap_o` and clears `flags_o` to 0 after that edge. An input change in that same cycle is absorbed and raises no flag.
- R5: With no read in progress, `int_n_o` goes low one edge after a masked-in flag appears. It stays low until an acknowledge, which drives it high after that edge.
- R6: While `rd_busy_i`=1, `int_n_o` does not fall. A change held during the read drives `int_n_o` low one edge after `stop_i`.
- R7: If an acknowledge during the read clears the held change before `stop_i`, `int_n_o` stays high after the STOP.
- R8: After reset: mask = 4'b1111, flags = 0 and `int_n_o` = 1. On the first edge after reset release, `snap_o` loads the inputs without raising a flag.
- R9: When `smp_clr_i` and `stop_i` coincide, the acknowledge wins and `int_n_o` stays high.
- R10: `mask_we_i`=1 at an edge loads `mask_d_i` into the mask. Bit i enables input i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_i | input | N_IN | Live input levels |
| smp_clr_i | input | 1 | Access acknowledge: sample the inputs, clear the flags, release the interrupt |
| rd_busy_i | input | 1 | A read transaction is in progress |
| stop_i | input | 1 | One-cycle pulse at a STOP condition |
| mask_we_i | input | 1 | Mask write strobe |
| mask_d_i | input | N_IN | New mask value |
| flags_o | output | N_IN | Sticky change flags |
| snap_o | output | N_IN | Snapshot register |
| int_n_o | output | 1 | Active-low latched interrupt |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is an input change and an acknowledge. The bench changes `port_i` on the very edge that carries `smp_clr_i`. It expects the new level in `snap_o` and no flag.

The second pair is the acknowledge and `stop_i` after a change held during a read. The bench expects `int_n_o` to stay high.

A random phase drives pulses with independent odds, so both collisions also recur there. A behavioural model judges them on every cycle.

// File: rtl/icd_pkg.sv
package icd_pkg;
    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_HOLD  = 2'd1,
        ST_FIRED = 2'd2
    } irq_st_e;
endpackage

// File: rtl/icd_tracker.sv
module icd_tracker #(
    parameter int N_IN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] port_i,
    input  logic            smp_clr_i,
    output logic [N_IN-1:0] flags_o,
    output logic [N_IN-1:0] snap_o
);
    logic            armed_q;
    logic [N_IN-1:0] snap_q;
    logic [N_IN-1:0] flag_q;
    logic [N_IN-1:0] diff;

    assign diff = snap_q ^ port_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            snap_q  <= '0;
            flag_q  <= '0;
        end else if (!armed_q) begin
            armed_q <= 1'b1;
            snap_q  <= port_i;
        end else if (smp_clr_i) begin
            snap_q  <= port_i;
            flag_q  <= '0;
        end else begin
            flag_q  <= flag_q | diff;
        end
    end

    assign flags_o = flag_q;
    assign snap_o  = snap_q;

    AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !smp_clr_i) |=> ((flag_q & $past(diff)) == $past(diff))); // R1
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_clr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R2
    AST_ACK_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        smp_clr_i |=> (flag_q == '0 && snap_q == $past(port_i))); // R4
endmodule

// File: rtl/icd_irq_fsm.sv
module icd_irq_fsm
    import icd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic rd_busy_i,
    input  logic stop_i,
    input  logic smp_clr_i,
    output logic int_n_o
);
    irq_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_QUIET: begin
                if (smp_clr_i)      st_d = ST_QUIET;
                else if (hit_i)     st_d = rd_busy_i ? ST_HOLD : ST_FIRED;
            end
            ST_HOLD: begin
                if (smp_clr_i)      st_d = ST_QUIET;
                else if (stop_i)    st_d = hit_i ? ST_FIRED : ST_QUIET;
            end
            ST_FIRED: begin
                if (smp_clr_i)      st_d = ST_QUIET;
            end
            default:                st_d = ST_QUIET;
        endcase
    end

    always_comb begin
        int_n_o = (st_q != ST_FIRED);
    end

    AST_FALL_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n_o) |-> $past(hit_i)); // R3
    AST_LOW_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n_o && !smp_clr_i) |=> !int_n_o); // R5
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        smp_clr_i |=> int_n_o); // R9
    AST_NO_FALL_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_n_o) |-> (!$past(rd_busy_i) || $past(stop_i))); // R6
    AST_DROP_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && stop_i && !smp_clr_i && !hit_i) |=> int_n_o); // R7
endmodule

// File: rtl/input_change_irq.sv
module input_change_irq
    import icd_pkg::*;
#(
    parameter int N_IN = 4,
    parameter logic [N_IN-1:0] MASK_RST = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] port_i,
    input  logic            smp_clr_i,
    input  logic            rd_busy_i,
    input  logic            stop_i,
    input  logic            mask_we_i,
    input  logic [N_IN-1:0] mask_d_i,
    output logic [N_IN-1:0] flags_o,
    output logic [N_IN-1:0] snap_o,
    output logic            int_n_o
);
    logic [N_IN-1:0] mask_q;
    logic [N_IN-1:0] flags;
    logic            hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= MASK_RST;
        else if (mask_we_i) mask_q <= mask_d_i;
    end

    icd_tracker #(.N_IN(N_IN)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_i    (port_i),
        .smp_clr_i (smp_clr_i),
        .flags_o   (flags),
        .snap_o    (snap_o)
    );

    assign hit     = |(flags & mask_q);
    assign flags_o = flags;

    icd_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .rd_busy_i (rd_busy_i),
        .stop_i    (stop_i),
        .smp_clr_i (smp_clr_i),
        .int_n_o   (int_n_o)
    );

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_i |=> (mask_q == $past(mask_d_i))); // R10
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (int_n_o && !hit) |=> int_n_o); // R3
endmodule

// File: tb/input_change_irq_tb_top.sv
`timescale 1ns/1ps
module input_change_irq_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] port = 4'b1010;
    logic         smp = 1'b0;
    logic         rd = 1'b0;
    logic         stp = 1'b0;
    logic         mwe = 1'b0;
    logic [N-1:0] md = '0;
    logic [N-1:0] flags, snap;
    logic         int_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    input_change_irq #(.N_IN(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .port_i(port), .smp_clr_i(smp),
        .rd_busy_i(rd), .stop_i(stp), .mask_we_i(mwe), .mask_d_i(md),
        .flags_o(flags), .snap_o(snap), .int_n_o(int_n)
    );

    // behavioural reference
    bit [N-1:0] m_snap = '0, m_flags = '0, m_mask = '1;
    bit m_low = 0, m_wait = 0, m_ready = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_snap = '0; m_flags = '0; m_mask = '1;
            m_low = 0; m_wait = 0; m_ready = 0;
        end else begin
            bit live;
            live = (m_flags & m_mask) != 0;
            if (smp) begin
                m_low = 0; m_wait = 0;
            end else if (m_low) begin
                m_low = 1;
            end else if (m_wait) begin
                if (stp) begin m_wait = 0; m_low = live; end
            end else if (live) begin
                if (rd) m_wait = 1; else m_low = 1;
            end
            if (!m_ready) begin
                m_snap = port; m_ready = 1;
            end else if (smp) begin
                m_snap = port; m_flags = '0;
            end else begin
                m_flags = m_flags | (m_snap ^ port);
            end
            if (mwe) m_mask = md;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            total++;
            if (flags !== m_flags) begin
                bad++; $display("FAIL R1/R2 model flags got=%b exp=%b", flags, m_flags);
            end
            total++;
            if (snap !== m_snap) begin
                bad++; $display("FAIL R4 model snapshot got=%b exp=%b", snap, m_snap);
            end
            total++;
            if (int_n !== !m_low) begin
                bad++; $display("FAIL R5/R6 model int_n got=%b exp=%b", int_n, !m_low);
            end
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++; $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic ack();
        smp = 1; cyc(); smp = 0;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk("R8 flags after reset", flags, 4'b0000);
        chk("R8 int_n after reset", {3'b0, int_n}, 4'b0001);
        chk("R8 snapshot loaded", snap, 4'b1010);
        // R1 change sets flag, R5 interrupt next edge, R2 sticky
        port = 4'b1011; cyc();
        chk("R1 flag set", flags, 4'b0001);
        cyc();
        chk("R5 int low", {3'b0, int_n}, 4'b0000);
        port = 4'b1010; cyc();
        chk("R2 flag sticky", flags, 4'b0001);
        chk("R5 int latched", {3'b0, int_n}, 4'b0000);
        ack();
        chk("R4 flags cleared", flags, 4'b0000);
        chk("R5 int released", {3'b0, int_n}, 4'b0001);
        // R10 mask write, R3 masked change flags only
        mwe = 1; md = 4'b0001; cyc(); mwe = 0;
        port = 4'b0010; cyc(); cyc(); cyc();
        chk("R3 flag despite mask", flags, 4'b1000);
        chk("R3 R10 int stays high", {3'b0, int_n}, 4'b0001);
        ack();
        mwe = 1; md = 4'b1111; cyc(); mwe = 0;
        // R6 deferral during read
        rd = 1; cyc();
        port = 4'b0000; cyc(); cyc(); cyc(); cyc();
        chk("R6 no int during read", {3'b0, int_n}, 4'b0001);
        rd = 0; stp = 1; cyc(); stp = 0;
        chk("R6 int at stop", {3'b0, int_n}, 4'b0000);
        ack();
        // R7 change read out before stop
        rd = 1; port = 4'b0001; cyc(); cyc();
        ack(); cyc();
        stp = 1; rd = 0; cyc(); stp = 0; cyc();
        chk("R7 int stays high", {3'b0, int_n}, 4'b0001);
        chk("R7 flags clear", flags, 4'b0000);
        // R9 ack and stop together
        rd = 1; port = 4'b0000; cyc(); cyc();
        smp = 1; stp = 1; cyc(); smp = 0; stp = 0; rd = 0; cyc(); cyc();
        chk("R9 ack wins over stop", {3'b0, int_n}, 4'b0001);
        // R4 change in the ack cycle is absorbed
        port = 4'b0100; smp = 1; cyc(); smp = 0; cyc();
        chk("R4 same-cycle change absorbed", flags, 4'b0000);
        chk("R4 snapshot takes new level", snap, 4'b0100);
        // random phase, judged by the model
        for (int i = 0; i < 3000; i++) begin
            port = ($urandom_range(0, 3) == 0) ? 4'($urandom) : port;
            smp  = ($urandom_range(0, 7) == 0);
            stp  = ($urandom_range(0, 7) == 0);
            mwe  = ($urandom_range(0, 15) == 0);
            md   = 4'($urandom);
            if ($urandom_range(0, 9) == 0) rd = ~rd;
            cyc();
        end
        smp = 0; stp = 0; mwe = 0; rd = 0;
        cyc();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule